// File: doc/BRIEF.md
# UART Receive Frame Queue

This block is the receive-side storage stage of a UART. It takes completed frames from the receive shift logic, each a data byte with parity, noise and framing error indications. It holds them until a reader (a CPU or a DMA engine) takes them out of a single output buffer. When queueing is enabled, a four-entry first-in first-out store sits in front of that buffer, so five frames can wait before any is lost. A reader that is slow to answer the buffer-not-empty condition therefore does not immediately lose data.

The reader always sees the oldest frame: its data and its own three error indications. The reader can clear the error indications of that frame without consuming it. A pop removes the frame, and the next stored one takes its place at the same clock edge. A full-queue flag has its own interrupt enable. A sticky overrun flag records that a frame was dropped. With queueing disabled, frames go straight into the output buffer, and the store is emptied.

Top module: `uart_rxq_buffer`

## Requirements
- R1: After reset, rbne_o, fifo_full_o, full_irq_o, ovr_o, rd_perr_o, rd_nerr_o and rd_ferr_o are all 0.
- R2: With fifo_en_i low, a frame written while the buffer is empty appears on rd_data_o and on the three flag outputs, with rbne_o high, one cycle after the wr_vld_i cycle.
- R3: With fifo_en_i high, up to five frames written without a pop are all kept, and they are read out in arrival order, each with its own data and flags.
- R4: A pop (rd_pop_i high while rbne_o is high) replaces the buffer frame at the same edge. The replacement is the oldest stored frame, or the frame written in that cycle if nothing else is stored. rbne_o stays high while any frame remains. A pop while rbne_o is low has no effect.
- R5: fifo_full_o is high exactly when all four queue entries are occupied, that is when five frames are held.
- R6: full_irq_o is high exactly when fifo_full_o and full_ie_i are both high.
- R7: A frame written while the buffer is occupied, with no pop in that cycle, is an overrun if the queue is disabled or full. The frame is discarded, the stored frames are unchanged, and ovr_o goes high on the next cycle. ovr_o stays high until a cycle with ovr_clr_i high and no new overrun.
- R8: err_clr_i clears the three flags of the frame in the buffer and leaves its data and every later frame's flags as they are. The flags of a frame that enters the buffer at that same edge are kept.
- R9: Driving fifo_en_i low discards all queue entries at the next edge and keeps the frame in the buffer.
- R10: A pop and a write in the same cycle with five frames held is not an overrun. Five frames are held afterwards, with the newest frame last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en_i | input | 1 | Enables the four-entry queue in front of the buffer |
| full_ie_i | input | 1 | Enables the full-queue interrupt |
| wr_vld_i | input | 1 | A received frame is offered this cycle |
| wr_data_i | input | DATA_W | Received data |
| wr_perr_i | input | 1 | Parity error of the offered frame |
| wr_nerr_i | input | 1 | Noise error of the offered frame |
| wr_ferr_i | input | 1 | Framing error of the offered frame |
| rd_pop_i | input | 1 | Reader removes the buffer frame |
| err_clr_i | input | 1 | Clears the error flags of the buffer frame |
| ovr_clr_i | input | 1 | Clears the sticky overrun flag |
| rd_data_o | output | DATA_W | Data of the buffer frame |
| rd_perr_o | output | 1 | Parity error of the buffer frame |
| rd_nerr_o | output | 1 | Noise error of the buffer frame |
| rd_ferr_o | output | 1 | Framing error of the buffer frame |
| rbne_o | output | 1 | Buffer holds a frame |
| fifo_full_o | output | 1 | All queue entries occupied |
| full_irq_o | output | 1 | Full-queue interrupt |
| ovr_o | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its defaults, DATA_W of 8 and FIFO_DEPTH of 4. The total capacity of five frames can then be filled in a handful of writes, so the full flag, the overrun edge and the pop-with-write at full are reached often under random traffic. Frequent enable drops in the random phase make the flush happen with partly filled queues, and random error bits together with clear requests cover per-frame flag ownership.

// File: rtl/uart_rxq_pkg.sv
// Shared types for the UART receive frame queue.
// Assumes the error field sits above the data bits in every stored word.
package uart_rxq_pkg;
    localparam int ERR_W = 3;

    typedef struct packed {
        logic perr;
        logic nerr;
        logic ferr;
    } rxq_err_t;
endpackage

// File: rtl/rxq_ring.sv
// Circular first-in first-out store of frame words.
// Assumes the caller never pushes into a full store without popping in the
// same cycle, and never pops an empty one. Flush wins over push and pop.
module rxq_ring #(
    parameter int WORD_W = 11,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_word_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] head_word_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WORD_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    assign head_word_o = slot_q[rd_ptr_q];
    assign empty_o     = (cnt_q == '0);
    assign full_o      = (cnt_q == FULL_CNT);

    // Stores the pushed word in the slot under the write pointer.
    always_ff @(posedge clk) begin
        if (push_i && !flush_i) slot_q[wr_ptr_q] <= push_word_i;
    end

    // Advances pointers and occupancy; flush empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_i) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
            else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i) |-> !full_o);
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !flush_i) |-> !empty_o);
endmodule

// File: rtl/rxq_hold_buf.sv
// Single receive buffer presented to the reader.
// Loading a word with load_vld_i low empties it and zeroes the flags.
// A load overrides a flag clear in the same cycle.
module rxq_hold_buf
    import uart_rxq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     load_vld_i,
    input  logic [DATA_W+ERR_W-1:0]  load_word_i,
    input  logic                     err_clr_i,
    output logic                     vld_o,
    output logic [DATA_W-1:0]        data_o,
    output rxq_err_t                 err_o
);
    rxq_err_t err_q;
    logic [DATA_W-1:0] data_q;
    logic vld_q;

    assign vld_o  = vld_q;
    assign data_o = data_q;
    assign err_o  = err_q;

    // Holds the reader-visible frame, its flags and its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            data_q <= '0;
            err_q  <= '0;
        end else if (load_i) begin
            vld_q  <= load_vld_i;
            data_q <= load_word_i[DATA_W-1:0];
            err_q  <= load_vld_i ? rxq_err_t'(load_word_i[DATA_W+ERR_W-1:DATA_W]) : '0;
        end else if (err_clr_i) begin
            err_q  <= '0;
        end
    end

    assert_clr_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr_i && !load_i) |=> (err_o == '0 && $stable(data_o)));
endmodule

// File: rtl/rxq_status.sv
// Sticky overrun flag and gated full-queue interrupt.
// A set in the same cycle as a clear leaves the flag set.
module rxq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic ovr_set_i,
    input  logic ovr_clr_i,
    input  logic full_i,
    input  logic full_ie_i,
    output logic ovr_o,
    output logic irq_o
);
    logic ovr_q;

    assign ovr_o = ovr_q;
    assign irq_o = full_i && full_ie_i;

    // Sets the overrun flag on a dropped frame, clears it on request.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovr_q <= 1'b0;
        else if (ovr_set_i) ovr_q <= 1'b1;
        else if (ovr_clr_i) ovr_q <= 1'b0;
    end

    assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_o && !ovr_clr_i) |=> ovr_o);
endmodule

// File: rtl/uart_rxq_buffer.sv
// UART receive frame queue: optional ring store in front of one buffer.
// Assumes at most one offered frame per cycle. A pop frees a slot for a
// write in the same cycle; the buffer refills at the edge of the pop.
module uart_rxq_buffer
    import uart_rxq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en_i,
    input  logic              full_ie_i,
    input  logic              wr_vld_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              wr_perr_i,
    input  logic              wr_nerr_i,
    input  logic              wr_ferr_i,
    input  logic              rd_pop_i,
    input  logic              err_clr_i,
    input  logic              ovr_clr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_perr_o,
    output logic              rd_nerr_o,
    output logic              rd_ferr_o,
    output logic              rbne_o,
    output logic              fifo_full_o,
    output logic              full_irq_o,
    output logic              ovr_o
);
    localparam int WORD_W = DATA_W + ERR_W;

    rxq_err_t          in_err, out_err;
    logic [WORD_W-1:0] in_word, head_word, load_word;
    logic buf_vld, ring_empty, ring_full;
    logic pop_hit, ring_push, ring_pop, buf_load, buf_load_vld, ovr_now;

    assign in_err.perr = wr_perr_i;
    assign in_err.nerr = wr_nerr_i;
    assign in_err.ferr = wr_ferr_i;
    assign in_word     = {in_err, wr_data_i};

    // Steers each offered frame and each pop between ring, buffer and drop.
    always_comb begin
        pop_hit      = rd_pop_i && buf_vld;
        ring_pop     = pop_hit && fifo_en_i && !ring_empty;
        ring_push    = wr_vld_i && fifo_en_i && buf_vld &&
                       (rd_pop_i ? !ring_empty : !ring_full);
        ovr_now      = wr_vld_i && buf_vld && !rd_pop_i && (!fifo_en_i || ring_full);
        buf_load     = pop_hit || (!buf_vld && wr_vld_i);
        buf_load_vld = ring_pop || wr_vld_i;
        load_word    = ring_pop ? head_word : in_word;
    end

    rxq_ring #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_ring (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (!fifo_en_i),
        .push_i      (ring_push),
        .push_word_i (in_word),
        .pop_i       (ring_pop),
        .head_word_o (head_word),
        .empty_o     (ring_empty),
        .full_o      (ring_full)
    );

    rxq_hold_buf #(.DATA_W(DATA_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (buf_load),
        .load_vld_i  (buf_load_vld),
        .load_word_i (load_word),
        .err_clr_i   (err_clr_i),
        .vld_o       (buf_vld),
        .data_o      (rd_data_o),
        .err_o       (out_err)
    );

    rxq_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_set_i (ovr_now),
        .ovr_clr_i (ovr_clr_i),
        .full_i    (ring_full),
        .full_ie_i (full_ie_i),
        .ovr_o     (ovr_o),
        .irq_o     (full_irq_o)
    );

    assign rd_perr_o   = out_err.perr;
    assign rd_nerr_o   = out_err.nerr;
    assign rd_ferr_o   = out_err.ferr;
    assign rbne_o      = buf_vld;
    assign fifo_full_o = ring_full;

    assert_empty_buf_empty_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rbne_o |-> ring_empty);
    assert_flush_on_disable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en_i |=> (ring_empty && !fifo_full_o));
    assert_drop_sets_ovr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld_i && rbne_o && !rd_pop_i && (!fifo_en_i || fifo_full_o)) |=> ovr_o);
    assert_drop_keeps_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld_i && rbne_o && !rd_pop_i && !err_clr_i) |=> ($stable(rd_data_o) && rbne_o));
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_irq_o |-> (fifo_full_o && full_ie_i));
    assert_full_only_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_o |-> rbne_o);
endmodule

// File: tb/test_uart_rxq_buffer.sv
module test_uart_rxq_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CAP = 5;

    logic clk = 1'b0;
    logic rst_n, fifo_en, full_ie, wr_vld, wr_perr, wr_nerr, wr_ferr;
    logic rd_pop, err_clr, ovr_clr;
    logic [DW-1:0] wr_data, rd_data;
    logic rd_perr, rd_nerr, rd_ferr, rbne, fifo_full, full_irq, ovr;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Reference state: frame words {perr,nerr,ferr,data}, oldest first.
    logic [DW+2:0] mq[$];
    bit m_ovr = 0;

    uart_rxq_buffer #(.DATA_W(DW), .FIFO_DEPTH(4)) i_uart_rxq_buffer (
        .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en), .full_ie_i(full_ie),
        .wr_vld_i(wr_vld), .wr_data_i(wr_data), .wr_perr_i(wr_perr),
        .wr_nerr_i(wr_nerr), .wr_ferr_i(wr_ferr), .rd_pop_i(rd_pop),
        .err_clr_i(err_clr), .ovr_clr_i(ovr_clr), .rd_data_o(rd_data),
        .rd_perr_o(rd_perr), .rd_nerr_o(rd_nerr), .rd_ferr_o(rd_ferr),
        .rbne_o(rbne), .fifo_full_o(fifo_full), .full_irq_o(full_irq), .ovr_o(ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_overrun(bit en, bit wr, bit pop, int occ);
        return wr && occ > 0 && !pop && (!en || occ == CAP);
    endfunction

    // Advances the reference by one clock from the inputs sampled at the edge.
    task automatic model_step();
        logic [DW+2:0] w;
        bit drop;
        if (!rst_n) begin
            mq.delete();
            m_ovr = 0;
            return;
        end
        w = {wr_perr, wr_nerr, wr_ferr, wr_data};
        drop = is_overrun(fifo_en, wr_vld, rd_pop, mq.size());
        if (!fifo_en) while (mq.size() > 1) void'(mq.pop_back());
        if (err_clr && mq.size() > 0) mq[0][DW+2:DW] = 3'b000;
        if (rd_pop && mq.size() > 0) void'(mq.pop_front());
        if (wr_vld && !drop) mq.push_back(w);
        if (drop) m_ovr = 1;
        else if (ovr_clr) m_ovr = 0;
    endtask

    task automatic compare_all();
        bit full_e;
        full_e = (mq.size() == CAP);
        chk("R4", "rbne", int'(rbne), int'(mq.size() > 0));
        if (mq.size() > 0) begin
            chk("R3", "data", int'(rd_data), int'(mq[0][DW-1:0]));
            chk("R8", "flags", int'({rd_perr, rd_nerr, rd_ferr}), int'(mq[0][DW+2:DW]));
        end else begin
            chk("R8", "flags empty", int'({rd_perr, rd_nerr, rd_ferr}), 0);
        end
        chk("R5", "fifo_full", int'(fifo_full), int'(full_e));
        chk("R6", "full_irq", int'(full_irq), int'(full_e && full_ie));
        chk("R7", "ovr", int'(ovr), int'(m_ovr));
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_in();
        wr_vld = 0; rd_pop = 0; err_clr = 0; ovr_clr = 0;
        wr_data = '0; wr_perr = 0; wr_nerr = 0; wr_ferr = 0;
    endtask

    task automatic put(input logic [DW-1:0] d, input logic [2:0] e);
        wr_vld = 1; wr_data = d; {wr_perr, wr_nerr, wr_ferr} = e;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd2024));
        idle_in();
        rst_n = 0; fifo_en = 0; full_ie = 0;
        @(negedge clk);
        repeat (3) step();
        // R1: reset state
        chk("R1", "rbne", int'(rbne), 0);
        chk("R1", "full", int'(fifo_full), 0);
        chk("R1", "irq", int'(full_irq), 0);
        chk("R1", "ovr", int'(ovr), 0);
        chk("R1", "flags", int'({rd_perr, rd_nerr, rd_ferr}), 0);
        rst_n = 1;

        // R2: bypass with queue disabled
        put(8'hA5, 3'b100); step(); idle_in();
        chk("R2", "bypass rbne", int'(rbne), 1);
        chk("R2", "bypass data", int'(rd_data), 'hA5);
        chk("R2", "bypass perr", int'(rd_perr), 1);
        put(8'h3C, 3'b000); step(); idle_in();
        chk("R7", "disabled drop keeps data", int'(rd_data), 'hA5);
        chk("R7", "disabled drop ovr", int'(ovr), 1);
        ovr_clr = 1; step(); idle_in();
        chk("R7", "ovr cleared", int'(ovr), 0);
        rd_pop = 1; step(); idle_in();
        chk("R4", "empty after pop", int'(rbne), 0);
        rd_pop = 1; step(); idle_in();
        chk("R4", "pop on empty ignored", int'(rbne), 0);

        // R3, R5, R6: fill five frames with the queue enabled
        fifo_en = 1; full_ie = 1;
        for (int i = 0; i < CAP; i++) begin
            put(8'(8'h10 + i), 3'(i)); step(); idle_in();
        end
        chk("R5", "full at five", int'(fifo_full), 1);
        chk("R6", "irq at full", int'(full_irq), 1);
        chk("R3", "no ovr at five", int'(ovr), 0);
        full_ie = 0; #1;
        chk("R6", "irq masked", int'(full_irq), 0);
        put(8'hEE, 3'b111); step(); idle_in();
        chk("R7", "sixth dropped ovr", int'(ovr), 1);
        chk("R7", "sixth dropped data", int'(rd_data), 'h10);
        ovr_clr = 1; step(); idle_in();

        // R10: pop with write at full
        rd_pop = 1; put(8'h77, 3'b010); step(); idle_in();
        chk("R10", "no ovr", int'(ovr), 0);
        chk("R10", "still full", int'(fifo_full), 1);
        chk("R10", "next head", int'(rd_data), 'h11);

        // R8: clear flags of the buffer frame only
        err_clr = 1; step(); idle_in();
        chk("R8", "flags cleared", int'({rd_perr, rd_nerr, rd_ferr}), 0);
        chk("R8", "data kept", int'(rd_data), 'h11);
        rd_pop = 1; step(); idle_in();
        chk("R8", "next flags intact", int'({rd_perr, rd_nerr, rd_ferr}), 2);

        // R9: disable flushes queue, keeps buffer
        fifo_en = 0; step(); fifo_en = 1;
        chk("R9", "buffer kept", int'(rbne), 1);
        chk("R9", "buffer data", int'(rd_data), 'h12);
        chk("R9", "not full", int'(fifo_full), 0);
        rd_pop = 1; step(); idle_in();
        chk("R9", "queue empty", int'(rbne), 0);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            wr_vld  = ($urandom % 100) < 50;
            wr_data = 8'($urandom);
            {wr_perr, wr_nerr, wr_ferr} = 3'($urandom);
            rd_pop  = ($urandom % 100) < 35;
            err_clr = ($urandom % 100) < 10;
            ovr_clr = ($urandom % 100) < 10;
            full_ie = ($urandom % 2) == 1;
            fifo_en = ($urandom % 100) >= 3;
            step();
        end
        idle_in();
        done = 1;
        finish_run();
    end
endmodule